// File: doc/BRIEF.md
# Partitioned Pixel Pack and Expand Unit

This block converts packed pixel data between fixed-point forms and 8-bit pixel forms. One operand word holds several signed fixed-point lanes. Each lane is shifted left by a scale amount and moved to an operation-specific binary point. It is then clamped into an 8-bit unsigned or 16-bit signed field. The reverse direction widens bytes into 16-bit fixed-point lanes, and a merge operation interleaves the bytes of two words.

A 3-bit operation select picks one of five operations. The scale amount comes from a status register that lives outside this block and arrives here as a plain input. All five operations share one set of scale-and-clamp lanes. An optional output register adds one cycle of latency and carries an input strobe to an output valid flag. Select codes that name no operation give a zero result and raise an illegal-operation flag.

Top module: `pixfmt_unit`

## Requirements
- R1: While rst_n is low, result, out_valid and illegal_op are all zero.
- R2: Select code 0 (16-bit pack): each signed 16-bit lane i of src_b is shifted left by scale[3:0] and arithmetic-shifted right by 7. The value is clamped to 0..255 and written to result byte i. Negative lanes give 0.
- R3: In the 16-bit pack, scale[4] has no effect on the result.
- R4: Select code 1 (32-bit pack): the result is src_a shifted left 8 bits, with the low byte of each 32-bit half replaced. That byte is the corresponding signed 32-bit half of src_b, shifted left by scale (5 bits), arithmetic-shifted right by 23 and clamped to 0..255. A shift of 31 never wraps before clamping.
- R5: Select code 2 (fixed-point pack): each signed 32-bit half i of src_b is shifted left by scale and arithmetic-shifted right by 16. It is saturated to -32768..32767 and written to 16-bit field i of the result.
- R6: Select code 3 (expand): byte i of src_b[31:0] is zero-extended and shifted left by 4 into 16-bit lane i of the result.
- R7: Select code 4 (merge): result byte 2i is byte i of src_b and result byte 2i+1 is byte i of src_a, for i = 0..3.
- R8: Select codes 5, 6 and 7 give a zero result with illegal_op high. Legal codes give illegal_op low.
- R9: With the output register enabled (default), out_valid equals in_valid from the previous clock edge. Result and illegal_op for an accepted input appear one cycle after it.
- R10: With the output register enabled, a cycle with in_valid low leaves result and illegal_op unchanged.
- R11: For the 16-bit pack and the fixed-point pack, result[63:32] is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; loads the output register |
| op_sel | input | 3 | Operation select (codes 0..4 legal) |
| scale | input | 5 | Scale shift amount from the status register |
| src_a | input | 64 | Source operand A |
| src_b | input | 64 | Source operand B |
| result | output | 64 | Converted data |
| out_valid | output | 1 | Strobe marking a fresh result |
| illegal_op | output | 1 | Select code names no operation |

## Verification
Every result, its illegal flag and its valid strobe are due exactly one clock edge after the edge that sampled in_valid high, because the default build has a single register stage. The bench drives each vector on a falling edge and computes the expected word from a behavioural model. It compares on the next falling edge, so exactly one rising edge lies between stimulus and sample. Cycles with in_valid low keep the previously modelled word, and the same comparison then checks that nothing moved.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;

   typedef enum logic [2:0] {
      OP_PACK16  = 3'd0,
      OP_PACK32  = 3'd1,
      OP_PACKFIX = 3'd2,
      OP_EXPAND  = 3'd3,
      OP_MERGE   = 3'd4
   } pix_op_e;

   // binary-point positions used by the pack operations
   localparam int FRAC_PACK16  = 7;
   localparam int FRAC_PACK32  = 23;
   localparam int FRAC_PACKFIX = 16;

   localparam int DEF_SCALE_W = 5;

endpackage

// File: rtl/pixfmt_scale_clamp.sv
module pixfmt_scale_clamp #(
   parameter int IN_W    = 16,
   parameter int SHIFT_W = 5,
   parameter int OUT_W   = 8
) (
   input  logic [IN_W-1:0]    din,
   input  logic [SHIFT_W-1:0] shl,
   input  logic [SHIFT_W-1:0] rsh,
   input  logic               sat_signed,
   output logic [OUT_W-1:0]   dout
);
   // room for the widest left shift without wrap
   localparam int EXT_W = IN_W + (1 << SHIFT_W) + 1;

   localparam logic signed [EXT_W-1:0] LO_U = EXT_W'(0);
   localparam logic signed [EXT_W-1:0] HI_U = EXT_W'(255);
   localparam logic signed [EXT_W-1:0] LO_S = EXT_W'(-32768);
   localparam logic signed [EXT_W-1:0] HI_S = EXT_W'(32767);

   if (IN_W < 2) begin : g_bad_in
      $error("pixfmt_scale_clamp: IN_W too small");
   end
   if (OUT_W != 8 && OUT_W != 16) begin : g_bad_out
      $error("pixfmt_scale_clamp: OUT_W must be 8 or 16");
   end

   logic signed [EXT_W-1:0] ext;
   logic signed [EXT_W-1:0] shifted;
   logic signed [EXT_W-1:0] moved;
   logic signed [EXT_W-1:0] lo_lim;
   logic signed [EXT_W-1:0] hi_lim;

   always_comb begin
      ext     = {{(EXT_W-IN_W){din[IN_W-1]}}, din};
      shifted = ext <<< shl;
      moved   = shifted >>> rsh;
      lo_lim  = sat_signed ? LO_S : LO_U;
      hi_lim  = sat_signed ? HI_S : HI_U;
      if (moved < lo_lim)
         dout = sat_signed ? LO_S[OUT_W-1:0] : LO_U[OUT_W-1:0];
      else if (moved > hi_lim)
         dout = sat_signed ? HI_S[OUT_W-1:0] : HI_U[OUT_W-1:0];
      else
         dout = moved[OUT_W-1:0];
      // R2
      if (!sat_signed && din[IN_W-1])
         neg_floor_chk: assert (dout == '0)
            else $error("negative lane did not clamp to zero");
   end

endmodule

// File: rtl/pixfmt_pack_core.sv
module pixfmt_pack_core
   import pixfmt_pkg::*;
#(
   parameter int WORD_W  = 64,
   parameter int SHIFT_W = DEF_SCALE_W
) (
   input  logic [WORD_W-1:0]   a,
   input  logic [WORD_W-1:0]   b,
   input  logic [2:0]          op,
   input  logic [SHIFT_W-1:0]  scale,
   output logic [WORD_W/2-1:0] pk16_res,
   output logic [WORD_W-1:0]   pk32_res,
   output logic [WORD_W/2-1:0] pkfix_res
);
   localparam int L16 = WORD_W / 16;
   localparam int L32 = WORD_W / 32;

   logic [SHIFT_W-1:0] shl16;
   logic [SHIFT_W-1:0] rsh16;
   logic [SHIFT_W-1:0] rsh32;
   logic               is_fix;

   // narrow pack uses one bit less of scale
   assign shl16  = {1'b0, scale[SHIFT_W-2:0]};
   assign rsh16  = SHIFT_W'(FRAC_PACK16);
   assign is_fix = (pix_op_e'(op) == OP_PACKFIX);
   assign rsh32  = is_fix ? SHIFT_W'(FRAC_PACKFIX) : SHIFT_W'(FRAC_PACK32);

   logic [7:0]  lane8  [L16];
   logic [15:0] lane16 [L32];

   for (genvar i = 0; i < L16; i++) begin : g_narrow
      pixfmt_scale_clamp #(
         .IN_W   (16),
         .SHIFT_W(SHIFT_W),
         .OUT_W  (8)
      ) u_lane (
         .din       (b[16*i +: 16]),
         .shl       (shl16),
         .rsh       (rsh16),
         .sat_signed(1'b0),
         .dout      (lane8[i])
      );
      assign pk16_res[8*i +: 8] = lane8[i];
   end

   for (genvar w = 0; w < L32; w++) begin : g_wide
      pixfmt_scale_clamp #(
         .IN_W   (32),
         .SHIFT_W(SHIFT_W),
         .OUT_W  (16)
      ) u_lane (
         .din       (b[32*w +: 32]),
         .shl       (scale),
         .rsh       (rsh32),
         .sat_signed(is_fix),
         .dout      (lane16[w])
      );
      assign pkfix_res[16*w +: 16] = lane16[w];
   end

   always_comb begin
      pk32_res = a << 8;
      for (int w = 0; w < L32; w++) begin
         pk32_res[32*w +: 8] = lane16[w][7:0];
      end
   end

endmodule

// File: rtl/pixfmt_byte_ops.sv
module pixfmt_byte_ops #(
   parameter int WORD_W = 64
) (
   input  logic [WORD_W/2-1:0] a_lo,
   input  logic [WORD_W/2-1:0] b_lo,
   output logic [WORD_W-1:0]   exp_res,
   output logic [WORD_W-1:0]   mrg_res
);
   localparam int NB = WORD_W / 16;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      assign exp_res[16*i +: 16] = {4'h0, b_lo[8*i +: 8], 4'h0};
      assign mrg_res[16*i +: 16] = {a_lo[8*i +: 8], b_lo[8*i +: 8]};
   end

endmodule

// File: rtl/pixfmt_unit.sv
module pixfmt_unit
   import pixfmt_pkg::*;
#(
   parameter int WORD_W  = 64,
   parameter int SCALE_W = DEF_SCALE_W,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [2:0]         op_sel,
   input  logic [SCALE_W-1:0] scale,
   input  logic [WORD_W-1:0]  src_a,
   input  logic [WORD_W-1:0]  src_b,
   output logic [WORD_W-1:0]  result,
   output logic               out_valid,
   output logic               illegal_op
);
   localparam int HALF = WORD_W / 2;

   if (WORD_W < 64 || (WORD_W % 64) != 0) begin : g_bad_word
      $error("pixfmt_unit: WORD_W must be a multiple of 64");
   end
   if (SCALE_W < 5) begin : g_bad_scale
      $error("pixfmt_unit: SCALE_W must cover a right shift of 23");
   end

   logic [HALF-1:0]   pk16_res;
   logic [WORD_W-1:0] pk32_res;
   logic [HALF-1:0]   pkfix_res;
   logic [WORD_W-1:0] exp_res;
   logic [WORD_W-1:0] mrg_res;
   logic [WORD_W-1:0] nxt_res;
   logic              nxt_ill;

   pixfmt_pack_core #(
      .WORD_W (WORD_W),
      .SHIFT_W(SCALE_W)
   ) u_pack (
      .a        (src_a),
      .b        (src_b),
      .op       (op_sel),
      .scale    (scale),
      .pk16_res (pk16_res),
      .pk32_res (pk32_res),
      .pkfix_res(pkfix_res)
   );

   pixfmt_byte_ops #(
      .WORD_W(WORD_W)
   ) u_bytes (
      .a_lo   (src_a[HALF-1:0]),
      .b_lo   (src_b[HALF-1:0]),
      .exp_res(exp_res),
      .mrg_res(mrg_res)
   );

   always_comb begin
      nxt_ill = 1'b0;
      case (pix_op_e'(op_sel))
         OP_PACK16:  nxt_res = {{HALF{1'b0}}, pk16_res};
         OP_PACK32:  nxt_res = pk32_res;
         OP_PACKFIX: nxt_res = {{HALF{1'b0}}, pkfix_res};
         OP_EXPAND:  nxt_res = exp_res;
         OP_MERGE:   nxt_res = mrg_res;
         default: begin
            nxt_res = '0;
            nxt_ill = 1'b1;
         end
      endcase
   end

   if (OUT_REG) begin : g_reg
      logic [WORD_W-1:0] res_q;
      logic              ill_q;
      logic              vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q <= '0;
            ill_q <= 1'b0;
            vld_q <= 1'b0;
         end else begin
            vld_q <= in_valid;
            if (in_valid) begin
               res_q <= nxt_res;
               ill_q <= nxt_ill;
            end
         end
      end

      assign result     = res_q;
      assign illegal_op = ill_q;
      assign out_valid  = vld_q;

      // R9
      valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid)
         else $error("strobe not carried to out_valid");
      // R9
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid)
         else $error("out_valid without an input strobe");
      // R10
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(result) && $stable(illegal_op)))
         else $error("output moved without an input strobe");
   end else begin : g_comb
      assign result     = nxt_res;
      assign illegal_op = nxt_ill;
      assign out_valid  = in_valid;
   end

   // R8
   illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |-> (result == '0))
      else $error("illegal select left a nonzero result");

endmodule

// File: tb/pixfmt_unit_tb.sv
module pixfmt_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_sel = 3'd0;
   logic [4:0]  scale = 5'd0;
   logic [63:0] src_a = 64'd0;
   logic [63:0] src_b = 64'd0;
   logic [63:0] result;
   logic        out_valid;
   logic        illegal_op;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   bit [63:0] e_res = 64'd0;
   bit        e_val = 1'b0;
   bit        e_ill = 1'b0;
   bit [2:0]  e_op = 3'd0;
   bit        e_sc4 = 1'b0;
   bit        e_fresh = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pixfmt_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op_sel    (op_sel),
      .scale     (scale),
      .src_a     (src_a),
      .src_b     (src_b),
      .result    (result),
      .out_valid (out_valid),
      .illegal_op(illegal_op)
   );

   function automatic bit [7:0] clamp_u8(longint v);
      if (v < 0) return 8'd0;
      if (v > 255) return 8'd255;
      return v[7:0];
   endfunction

   function automatic bit [15:0] clamp_s16(longint v);
      if (v < -32768) return 16'h8000;
      if (v > 32767) return 16'h7fff;
      return v[15:0];
   endfunction

   function automatic bit [63:0] model(bit [2:0] op, bit [4:0] sc,
                                       bit [63:0] a, bit [63:0] b);
      bit [63:0] r;
      longint s;
      longint v;
      r = 64'd0;
      case (op)
         3'd0: for (int i = 0; i < 4; i++) begin
            s = $signed(b[16*i +: 16]);
            v = (s <<< sc[3:0]) >>> 7;
            r[8*i +: 8] = clamp_u8(v);
         end
         3'd1: begin
            r = a << 8;
            for (int w = 0; w < 2; w++) begin
               s = $signed(b[32*w +: 32]);
               v = (s <<< sc) >>> 23;
               r[32*w +: 8] = clamp_u8(v);
            end
         end
         3'd2: for (int w = 0; w < 2; w++) begin
            s = $signed(b[32*w +: 32]);
            v = (s <<< sc) >>> 16;
            r[16*w +: 16] = clamp_s16(v);
         end
         3'd3: for (int i = 0; i < 4; i++)
            r[16*i +: 16] = {4'h0, b[8*i +: 8], 4'h0};
         3'd4: for (int i = 0; i < 4; i++)
            r[16*i +: 16] = {a[8*i +: 8], b[8*i +: 8]};
         default: r = 64'd0;
      endcase
      return r;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string res_tag();
      if (!e_fresh) return "R10 hold";
      case (e_op)
         3'd0: return e_sc4 ? "R3 pack16 scale bit4" : "R2 pack16";
         3'd1: return "R4 pack32";
         3'd2: return "R5 packfix";
         3'd3: return "R6 expand";
         3'd4: return "R7 merge";
         default: return "R8 illegal result";
      endcase
   endfunction

   task automatic compare_now();
      chk("R9 out_valid", {63'd0, out_valid}, {63'd0, e_val});
      chk("R8 illegal_op", {63'd0, illegal_op}, {63'd0, e_ill});
      chk(res_tag(), result, e_res);
      if (e_fresh && (e_op == 3'd0 || e_op == 3'd2))
         chk("R11 upper half", {32'd0, result[63:32]}, 64'd0);
   endtask

   task automatic apply(bit [2:0] op, bit [4:0] sc, bit [63:0] a,
                        bit [63:0] b, bit v);
      @(negedge clk);
      compare_now();
      op_sel   = op;
      scale    = sc;
      src_a    = a;
      src_b    = b;
      in_valid = v;
      e_val    = v;
      if (v) begin
         e_res   = model(op, sc, a, b);
         e_ill   = (op > 3'd4);
         e_op    = op;
         e_sc4   = sc[4];
         e_fresh = 1'b1;
      end else begin
         e_fresh = 1'b0;
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_bad++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      src_a = 64'hffff_ffff_ffff_ffff;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 result", result, 64'd0);
      chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
      chk("R1 illegal_op", {63'd0, illegal_op}, 64'd0);
      rst_n = 1'b1;

      // R2 lanes: small, just over binary point, positive overflow, negative
      apply(3'd0, 5'd0,  64'd0, 64'h8000_7fff_0080_0001, 1'b1);
      apply(3'd0, 5'd3,  64'd0, 64'hffff_0040_0010_1000, 1'b1);
      // R3 scale bit4 set must behave as scale[3:0]
      apply(3'd0, 5'h13, 64'd0, 64'h0001_0040_0010_0100, 1'b1);
      apply(3'd0, 5'h10, 64'h1, 64'h0100_0200_0300_7f80, 1'b1);
      // R4 pack32 with small and full-width shifts
      apply(3'd1, 5'd0,  64'h1122_3344_5566_7788, 64'h0080_0000_0100_0000, 1'b1);
      apply(3'd1, 5'd31, 64'hdead_beef_0bad_f00d, 64'h0000_0001_ffff_ffff, 1'b1);
      apply(3'd1, 5'd31, 64'h0, 64'h8000_0000_7fff_ffff, 1'b1);
      // R5 packfix: in range, positive saturation, negative saturation
      apply(3'd2, 5'd0,  64'd0, 64'hfff0_0000_0012_3456, 1'b1);
      apply(3'd2, 5'd31, 64'd0, 64'h8000_0000_0000_0001, 1'b1);
      apply(3'd2, 5'd8,  64'd0, 64'h7fff_ffff_ffff_ff00, 1'b1);
      // R6 expand and R7 merge
      apply(3'd3, 5'd7,  64'hffff_ffff_ffff_ffff, 64'haaaa_aaaa_1234_56f8, 1'b1);
      apply(3'd4, 5'd0,  64'h9999_9999_4433_2211, 64'h7777_7777_ddcc_bbaa, 1'b1);
      // R8 illegal codes
      apply(3'd5, 5'd1,  64'h1, 64'h2, 1'b1);
      apply(3'd7, 5'd1,  64'h1, 64'h2, 1'b1);
      // R10 idle cycles with changing inputs hold the illegal result
      apply(3'd4, 5'd0,  64'h1234, 64'h5678, 1'b0);
      apply(3'd6, 5'd9,  64'hffff, 64'heeee, 1'b1);
      apply(3'd3, 5'd0,  64'h0, 64'h0000_00ff, 1'b1);
      apply(3'd0, 5'd2,  64'h5, 64'h7fff_7fff, 1'b0);
      apply(3'd1, 5'd2,  64'h5, 64'h7fff_7fff, 1'b0);

      for (int k = 0; k < 800; k++) begin
         bit [63:0] ra;
         bit [63:0] rb;
         ra = {$urandom(), $urandom()};
         rb = {$urandom(), $urandom()};
         apply(3'($urandom_range(0, 7)), 5'($urandom_range(0, 31)),
               ra, rb, ($urandom_range(0, 3) != 0));
      end

      @(negedge clk);
      compare_now();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule